// File: doc/BRIEF.md
# Morse Symbol Encoder

This block is a synchronous state machine that turns keying requests into a stream of 3-bit Morse symbol codes. Four request lines ask for a dot, a dash, a character gap or a word gap. The encoder accepts one request while it is free and then holds the matching symbol code on its output bus for the length that Morse timing requires. Time is counted in units, and one unit is a parameterised number of clocks. A receiver on the other side of the bus reads one code per unit and so never has to measure pulse widths.

The request side behaves like a ready handshake. `busy_o` low means ready. A request that is present at a rising clock edge while `busy_o` is low is taken at that edge. While `busy_o` is high, the requester is back-pressured: any requests it drives are dropped, not queued. Requests are levels sampled at clock edges. The encoder never holds a request back, so the requester must hold it until it sees `busy_o` rise.

Top module: `morse_sym_encoder`

## Requirements
- R1: Reset is active-low and synchronous. Any edge with `rst_n` low leaves `sym_o` = 3'b000 and `busy_o` = 0, whatever the request lines carry.
- R2: Symbol codes on `sym_o`: 3'b000 quiet, 3'b001 dot, 3'b010 dash, 3'b011 character gap, 3'b100 word gap. No other value ever appears.
- R3: A request seen at an edge while `busy_o` is low is accepted at that edge. From the next cycle on, `busy_o` is 1 and `sym_o` carries that request's code.
- R4: When several request lines are high at acceptance, the order of precedence is word gap, then character gap, then dash, then dot.
- R5: A dot holds 3'b001 for exactly 1 unit (UNIT_CLKS cycles).
- R6: A dash holds 3'b010 for exactly 3 units.
- R7: Each dot or dash is followed by exactly 1 unit of 3'b000 with `busy_o` still 1. After that, `busy_o` falls.
- R8: A character gap holds 3'b011 for exactly 3 units. `busy_o` falls right after it, with no trailing quiet unit.
- R9: A word gap holds 3'b100 for exactly 7 units. `busy_o` falls right after it.
- R10: Requests driven while `busy_o` is 1 are ignored. The symbol in progress keeps its code and length, and no symbol follows it.
- R11: While idle with no request, `sym_o` stays 3'b000 and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dot_req | input | 1 | Request a dot |
| dash_req | input | 1 | Request a dash |
| cgap_req | input | 1 | Request a character gap |
| wgap_req | input | 1 | Request a word gap |
| sym_o | output | 3 | Registered symbol code |
| busy_o | output | 1 | High while a symbol or its gap is in progress (0 = ready) |

## Verification
Both outputs are registered, so a request driven before edge N shows on `sym_o` and `busy_o` one cycle later. After that, the code lasts exactly its length in cycles, then comes the quiet unit where R7 calls for it, and then `busy_o` falls in the following cycle. The bench drives inputs on falling edges and compares the outputs on every falling edge against a cycle-by-cycle expectation built from the request's length and code. A symbol that is too long or too short, or a quiet unit that is missing, therefore fails in the exact cycle where it diverges. Random request noise is driven throughout each busy period, so the R10 drops are checked in every one of those cycles.

// File: rtl/morse_enc_pkg.sv
package morse_enc_pkg;

  typedef enum logic [2:0] {
    SYM_QUIET = 3'b000,
    SYM_DOT   = 3'b001,
    SYM_DASH  = 3'b010,
    SYM_CGAP  = 3'b011,
    SYM_WGAP  = 3'b100
  } sym_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DOT,
    ST_DASH,
    ST_MGAP,
    ST_CGAP,
    ST_WGAP
  } enc_state_t;

  // request vector bit positions; a higher index wins arbitration
  localparam int REQ_DOT  = 0;
  localparam int REQ_DASH = 1;
  localparam int REQ_CGAP = 2;
  localparam int REQ_WGAP = 3;
  localparam int REQ_N    = 4;

endpackage

// File: rtl/morse_req_arb.sv
module morse_req_arb
  import morse_enc_pkg::*;
(
  input  logic [REQ_N-1:0] req_i,
  output logic [REQ_N-1:0] grant_o
);

  always_comb begin
    grant_o = '0;
    for (int i = 0; i < REQ_N; i++) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/morse_unit_timer.sv
module morse_unit_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/morse_enc_fsm.sv
module morse_enc_fsm
  import morse_enc_pkg::*;
#(
  parameter int UNIT_CLKS  = 4,
  parameter int DOT_UNITS  = 1,
  parameter int DASH_UNITS = 3,
  parameter int CGAP_UNITS = 3,
  parameter int WGAP_UNITS = 7,
  parameter int MGAP_UNITS = 1,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] req_i,
  input  logic [REQ_N-1:0] grant_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic [2:0]       sym_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] DOT_LEN  = CNT_W'(DOT_UNITS  * UNIT_CLKS - 1);
  localparam logic [CNT_W-1:0] DASH_LEN = CNT_W'(DASH_UNITS * UNIT_CLKS - 1);
  localparam logic [CNT_W-1:0] CGAP_LEN = CNT_W'(CGAP_UNITS * UNIT_CLKS - 1);
  localparam logic [CNT_W-1:0] WGAP_LEN = CNT_W'(WGAP_UNITS * UNIT_CLKS - 1);
  localparam logic [CNT_W-1:0] MGAP_LEN = CNT_W'(MGAP_UNITS * UNIT_CLKS - 1);

  enc_state_t state_q, state_d;
  sym_t       sym_q, sym_d;
  logic       accept;
  logic       mark_done;

  assign accept    = (state_q == ST_IDLE) && (|req_i);
  assign mark_done = tmr_zero_i && (state_q == ST_DOT || state_q == ST_DASH);

  always_comb begin
    state_d    = state_q;
    sym_d      = sym_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (accept) begin
      tmr_load_o = 1'b1;
      if (grant_i[REQ_WGAP]) begin
        state_d = ST_WGAP; sym_d = SYM_WGAP; tmr_val_o = WGAP_LEN;
      end else if (grant_i[REQ_CGAP]) begin
        state_d = ST_CGAP; sym_d = SYM_CGAP; tmr_val_o = CGAP_LEN;
      end else if (grant_i[REQ_DASH]) begin
        state_d = ST_DASH; sym_d = SYM_DASH; tmr_val_o = DASH_LEN;
      end else begin
        state_d = ST_DOT;  sym_d = SYM_DOT;  tmr_val_o = DOT_LEN;
      end
    end else if (mark_done) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = MGAP_LEN;
      state_d    = ST_MGAP;
      sym_d      = SYM_QUIET;
    end else if (tmr_zero_i && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      sym_d   = SYM_QUIET;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sym_q   <= SYM_QUIET;
    end else begin
      state_q <= state_d;
      sym_q   <= sym_d;
    end
  end

  assign sym_o  = sym_q;
  assign busy_o = (state_q != ST_IDLE);

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_o <= 3'b100);                                                  // R2
  AST_TAKE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && |req_i) |=> busy_o && sym_o != 3'b000);                // R3
  AST_WORD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i[REQ_WGAP]) |=> sym_o == 3'b100);                 // R4
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_i));                                                // R4
  AST_MARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((sym_o == 3'b001 || sym_o == 3'b010) && tmr_zero_i) |=> busy_o && sym_o == 3'b000); // R7
  AST_CGAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_o == 3'b011 && tmr_zero_i) |=> !busy_o);                      // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tmr_zero_i) |=> $stable(sym_o) && busy_o);             // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i == '0) |=> !busy_o && sym_o == 3'b000);          // R11

endmodule

// File: rtl/morse_sym_encoder.sv
module morse_sym_encoder
  import morse_enc_pkg::*;
#(
  parameter int UNIT_CLKS  = 4,
  parameter int DOT_UNITS  = 1,
  parameter int DASH_UNITS = 3,
  parameter int CGAP_UNITS = 3,
  parameter int WGAP_UNITS = 7,
  parameter int MGAP_UNITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dot_req,
  input  logic       dash_req,
  input  logic       cgap_req,
  input  logic       wgap_req,
  output logic [2:0] sym_o,
  output logic       busy_o
);

  localparam int MAX_U01 = (DOT_UNITS > DASH_UNITS) ? DOT_UNITS : DASH_UNITS;
  localparam int MAX_U23 = (CGAP_UNITS > WGAP_UNITS) ? CGAP_UNITS : WGAP_UNITS;
  localparam int MAX_U02 = (MAX_U01 > MAX_U23) ? MAX_U01 : MAX_U23;
  localparam int MAX_U   = (MAX_U02 > MGAP_UNITS) ? MAX_U02 : MGAP_UNITS;
  localparam int MAX_LEN = MAX_U * UNIT_CLKS;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [REQ_N-1:0] req_vec;
  logic [REQ_N-1:0] grant;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  assign req_vec = {wgap_req, cgap_req, dash_req, dot_req};

  morse_req_arb u_arb (
    .req_i   (req_vec),
    .grant_o (grant)
  );

  morse_unit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  morse_enc_fsm #(
    .UNIT_CLKS  (UNIT_CLKS),
    .DOT_UNITS  (DOT_UNITS),
    .DASH_UNITS (DASH_UNITS),
    .CGAP_UNITS (CGAP_UNITS),
    .WGAP_UNITS (WGAP_UNITS),
    .MGAP_UNITS (MGAP_UNITS),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_vec),
    .grant_i    (grant),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sym_o      (sym_o),
    .busy_o     (busy_o)
  );

endmodule

// File: tb/sim_morse_sym_encoder.sv
module sim_morse_sym_encoder;

  localparam int U = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dot_req = 1'b0, dash_req = 1'b0, cgap_req = 1'b0, wgap_req = 1'b0;
  logic [2:0] sym_o;
  logic       busy_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  morse_sym_encoder #(.UNIT_CLKS(U)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dot_req(dot_req), .dash_req(dash_req), .cgap_req(cgap_req), .wgap_req(wgap_req),
    .sym_o(sym_o), .busy_o(busy_o)
  );

  // r = {word, char, dash, dot}
  function automatic logic [2:0] exp_code(input logic [3:0] r);
    if (r[3]) return 3'b100;
    if (r[2]) return 3'b011;
    if (r[1]) return 3'b010;
    return 3'b001;
  endfunction

  function automatic int exp_units(input logic [3:0] r);
    if (r[3]) return 7;
    if (r[2]) return 3;
    if (r[1]) return 3;
    return 1;
  endfunction

  function automatic string exp_tag(input logic [3:0] r);
    if (r[3]) return "R9";
    if (r[2]) return "R8";
    if (r[1]) return "R6";
    return "R5";
  endfunction

  task automatic drive(input logic [3:0] r);
    {wgap_req, cgap_req, dash_req, dot_req} = r;
  endtask

  task automatic chk(input string tag, input logic [2:0] es, input logic eb);
    n_vec++;
    if (sym_o !== es || busy_o !== eb) begin
      n_bad++;
      $display("FAIL %s: sym=%b busy=%b expected sym=%b busy=%b at %0t",
               tag, sym_o, busy_o, es, eb, $time);
    end
  endtask

  // caller stands at a falling edge with busy low; r must be nonzero
  task automatic run(input logic [3:0] r, input bit noise, input string tag);
    int   len;
    int   gap;
    logic [2:0] c;
    len = exp_units(r) * U;
    gap = (r[3] || r[2]) ? 0 : U;
    c   = exp_code(r);
    drive(r);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk((k == 0) ? tag : exp_tag(r), c, 1'b1);   // R3 first cycle, then length
      drive(noise ? 4'($urandom) : 4'b0);            // R10 noise while busy
    end
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      chk("R7", 3'b000, 1'b1);
      drive(noise ? 4'($urandom) : 4'b0);
    end
    @(negedge clk);
    chk(noise ? "R10" : "R7", 3'b000, 1'b0);
    drive(4'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset with requests asserted
    drive(4'b1111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 3'b000, 1'b0);
    drive(4'b0);
    rst_n = 1'b1;
    // R11: quiet idle
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11", 3'b000, 1'b0);
    end
    run(4'b0001, 1'b0, "R3");
    run(4'b0010, 1'b0, "R3");
    run(4'b0100, 1'b0, "R3");
    run(4'b1000, 1'b0, "R3");
    run(4'b1111, 1'b0, "R4");
    run(4'b0111, 1'b0, "R4");
    run(4'b0011, 1'b0, "R4");
    run(4'b0101, 1'b1, "R4");
    run(4'b0001, 1'b1, "R10");
    // mid-symbol reset returns to quiet (R1)
    drive(4'b0010);
    @(negedge clk);
    drive(4'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 3'b000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 3'b000, 1'b0);
    // constrained random: nonzero request, noise while busy
    for (int i = 0; i < 80; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (r == 4'b0) r = 4'b0001;
      run(r, 1'b1, "R2");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule